// File: doc/BRIEF.md
# Three-Wire Synthesizer Control Interface

This block is the control front end of a frequency synthesizer. A host writes one 27-bit programming word over a three-wire bus made of a data line, a bit clock and an enable strobe. The block shifts bits in only while enable is high, and sampling happens on the rising edge of the bus clock. When enable falls, the block checks that exactly 27 bits arrived. A good frame is then split into the synthesizer's settings. A frame of any other length is dropped.

The three bus lines are asynchronous to the system clock. They are synchronised, and their edges are found in the system clock domain. The port, test, drive and pump-current fields take effect as soon as the frame is accepted. The 17-bit divide ratio, the prescaler enable and the reference ratio select are held pending. They are applied only on a one-cycle terminal-count strobe from the programmable divider, so a retune never cuts a divider cycle short. The block has no streaming interface: every input and output is a plain control level or a one-cycle strobe, with no back-pressure.

Top module: `synth_ctrl_if`

## Requirements
- R1: After reset, every output is 0: divide ratio, prescaler enable, reference select, pump current, drive disable, test enable, port outputs, pump mode and monitor route.
- R2: The word is received MSB first. Its bit layout, from bit 26 down to bit 0, is: port bits P2 P1 P0 in bits 26..24, test enable in bit 23, drive disable in bit 22, pump-current select in bit 21, reference select in bits 20..18, prescaler enable in bit 17, and divide ratio in bits 16..0. `drive_off`, `cp_hi` and `test_en` take the new values within 6 system clocks after enable falls, without waiting for the divider.
- R3: Bus clock edges that occur while enable is low shift nothing in and change no output.
- R4: When enable falls after a bit count other than 27, the frame is discarded. No output changes, and no divider update is left pending.
- R5: `div_ratio`, `presc_en` and `ref_sel` keep their old values until `div_tc` is high after a frame has been accepted. They take the pending values on the clock edge at which `div_tc` is sampled high. A `div_tc` with nothing pending changes nothing.
- R6: If `div_tc` is high in the same cycle in which a frame is accepted, the divider fields take that frame's values at that same edge. Nothing remains pending afterwards.
- R7: A frame accepted while an earlier one is still pending replaces it. The next `div_tc` applies only the newest frame.
- R8: With test enable 0, `port_out` equals P2..P0. With test enable 1, `port_out[2]` equals P2 and `port_out[1:0]` are 0.
- R9: `cp_mode` encodes the pump test mode as 0 normal, 1 forced sink, 2 forced source and 3 disabled. With test enable 0 it is 0. With test enable 1, P1P0 = 00 gives 1, 01 gives 2, 10 gives 3, and 11 gives 0 with `mon_route` = 1. `mon_route` is 0 in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_clk | input | 1 | Bus bit clock, asynchronous |
| bus_data | input | 1 | Bus serial data, asynchronous |
| bus_en | input | 1 | Bus enable strobe, asynchronous |
| div_tc | input | 1 | One-cycle divider terminal-count strobe |
| div_ratio | output | 17 | Programmable divide ratio |
| presc_en | output | 1 | Divide-by-two prescaler enable |
| ref_sel | output | 3 | Reference divider ratio select |
| cp_hi | output | 1 | Charge pump high-current select |
| drive_off | output | 1 | Varactor drive disable |
| test_en | output | 1 | Test mode enable |
| port_out | output | 3 | Switching port outputs |
| cp_mode | output | 2 | Pump test mode (0 normal, 1 sink, 2 source, 3 off) |
| mon_route | output | 1 | Monitor signals routed to the two low ports |

## Verification
Two events can fall in the same cycle: a frame being accepted after the enable edge has passed through the synchroniser, and the divider's terminal-count strobe. The bench counts the synchroniser delay from the cycle in which it drops enable and raises `div_tc` exactly in the acceptance cycle. It then expects the divider fields of that frame on the very next sample, and a later strobe to leave them unchanged. It also puts a second frame on top of a pending one and judges that a single strobe applies only the newer frame.

// File: rtl/synth_ctrl_pkg.sv
package synth_ctrl_pkg;
  localparam int NDIV_W   = 17;
  localparam int REF_W    = 3;
  localparam int PORT_W   = 3;
  localparam int WORD_LEN = PORT_W + 3 + REF_W + 1 + NDIV_W;
  localparam int CNT_W    = $clog2(WORD_LEN + 2);

  typedef struct packed {
    logic [PORT_W-1:0] port;
    logic              t0;
    logic              os;
    logic              c0;
    logic [REF_W-1:0]  ref_sel;
    logic              pe;
    logic [NDIV_W-1:0] ndiv;
  } ctrl_word_t;

  typedef enum logic [1:0] {
    CP_NORMAL = 2'd0,
    CP_SINK   = 2'd1,
    CP_SOURCE = 2'd2,
    CP_OFF    = 2'd3
  } cp_mode_t;
endpackage

// File: rtl/bus_sync.sv
module bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= din;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last <= 1'b0;
    else last <= chain[STAGES-1];
  end

  assign lvl  = chain[STAGES-1];
  assign rise = chain[STAGES-1] & ~last;
  assign fall = ~chain[STAGES-1] & last;
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter
  import synth_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_lvl,
  input  logic       en_rise,
  input  logic       en_fall,
  input  logic       bclk_rise,
  input  logic       data_lvl,
  output logic       commit,
  output ctrl_word_t word
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_OK  = CNT_W'(WORD_LEN);

  logic [WORD_LEN-1:0] shreg;
  logic [CNT_W-1:0]    bit_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (en_rise) begin
      bit_cnt <= '0;
    end else if (en_lvl && bclk_rise) begin
      shreg <= {shreg[WORD_LEN-2:0], data_lvl};
      if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign commit = en_fall && (bit_cnt == CNT_OK);
  assign word   = ctrl_word_t'(shreg);

  assert_no_shift_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_lvl |=> $stable(shreg));
endmodule

// File: rtl/shadow_regs.sv
module shadow_regs
  import synth_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  ctrl_word_t        word,
  input  logic              div_tc,
  output logic [NDIV_W-1:0] div_ratio,
  output logic              presc_en,
  output logic [REF_W-1:0]  ref_sel,
  output logic              cp_hi,
  output logic              drive_off,
  output logic              test_en,
  output logic [PORT_W-1:0] port_bits
);
  ctrl_word_t pend;
  logic       pend_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cp_hi     <= 1'b0;
      drive_off <= 1'b0;
      test_en   <= 1'b0;
      port_bits <= '0;
    end else if (commit) begin
      cp_hi     <= word.c0;
      drive_off <= word.os;
      test_en   <= word.t0;
      port_bits <= word.port;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= '0;
      pend_v    <= 1'b0;
      div_ratio <= '0;
      presc_en  <= 1'b0;
      ref_sel   <= '0;
    end else begin
      if (commit && div_tc) begin
        div_ratio <= word.ndiv;
        presc_en  <= word.pe;
        ref_sel   <= word.ref_sel;
        pend_v    <= 1'b0;
      end else if (commit) begin
        pend   <= word;
        pend_v <= 1'b1;
      end else if (div_tc && pend_v) begin
        div_ratio <= pend.ndiv;
        presc_en  <= pend.pe;
        ref_sel   <= pend.ref_sel;
        pend_v    <= 1'b0;
      end
    end
  end

  assert_div_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !div_tc |=> ($stable(div_ratio) && $stable(ref_sel) && $stable(presc_en)));
  assert_tc_drains_R6: assert property (@(posedge clk) disable iff (!rst_n)
    div_tc |=> !pend_v);
  assert_immediate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (drive_off == $past(word.os) && cp_hi == $past(word.c0)));
endmodule

// File: rtl/synth_ctrl_if.sv
module synth_ctrl_if
  import synth_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_clk,
  input  logic              bus_data,
  input  logic              bus_en,
  input  logic              div_tc,
  output logic [NDIV_W-1:0] div_ratio,
  output logic              presc_en,
  output logic [REF_W-1:0]  ref_sel,
  output logic              cp_hi,
  output logic              drive_off,
  output logic              test_en,
  output logic [PORT_W-1:0] port_out,
  output logic [1:0]        cp_mode,
  output logic              mon_route
);
  localparam int NLINES = 3;

  logic [NLINES-1:0] raw_in, s_lvl, s_rise, s_fall;
  logic              commit;
  ctrl_word_t        word;
  logic [PORT_W-1:0] port_bits;
  logic              f_sink, f_src, f_off;
  cp_mode_t          mode;

  assign raw_in = {bus_en, bus_data, bus_clk};

  generate
    for (genvar k = 0; k < NLINES; k++) begin : g_sync
      bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(raw_in[k]),
        .lvl(s_lvl[k]), .rise(s_rise[k]), .fall(s_fall[k]));
    end
  endgenerate

  frame_shifter u_shift (
    .clk(clk), .rst_n(rst_n),
    .en_lvl(s_lvl[2]), .en_rise(s_rise[2]), .en_fall(s_fall[2]),
    .bclk_rise(s_rise[0]), .data_lvl(s_lvl[1]),
    .commit(commit), .word(word));

  shadow_regs u_shadow (
    .clk(clk), .rst_n(rst_n), .commit(commit), .word(word), .div_tc(div_tc),
    .div_ratio(div_ratio), .presc_en(presc_en), .ref_sel(ref_sel),
    .cp_hi(cp_hi), .drive_off(drive_off), .test_en(test_en),
    .port_bits(port_bits));

  always_comb begin
    f_sink    = test_en && (port_bits[1:0] == 2'b00);
    f_src     = test_en && (port_bits[1:0] == 2'b01);
    f_off     = test_en && (port_bits[1:0] == 2'b10);
    mon_route = test_en && (port_bits[1:0] == 2'b11);
    if (f_sink)      mode = CP_SINK;
    else if (f_src)  mode = CP_SOURCE;
    else if (f_off)  mode = CP_OFF;
    else             mode = CP_NORMAL;
    cp_mode  = mode;
    port_out = test_en ? {port_bits[PORT_W-1], {(PORT_W-1){1'b0}}} : port_bits;
  end

  assert_mode_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({f_sink, f_src, f_off, mon_route}));
  assert_low_ports_R8: assert property (@(posedge clk) disable iff (!rst_n)
    test_en |-> (port_out[1:0] == 2'b00));
endmodule

// File: tb/synth_ctrl_if_bench.sv
`timescale 1ns/1ps
module synth_ctrl_if_bench;
  localparam int HALF = 6;

  logic clk = 0, rst_n = 0;
  logic bus_clk = 0, bus_data = 0, bus_en = 0, div_tc = 0;
  logic [16:0] div_ratio;
  logic presc_en, cp_hi, drive_off, test_en, mon_route;
  logic [2:0] ref_sel, port_out;
  logic [1:0] cp_mode;

  int checks = 0, errors = 0;
  logic [26:0] imm_w, div_w, pend_w;
  bit pend_v;

  always #5 clk = ~clk;

  synth_ctrl_if u_synth_ctrl_if (
    .clk(clk), .rst_n(rst_n), .bus_clk(bus_clk), .bus_data(bus_data),
    .bus_en(bus_en), .div_tc(div_tc), .div_ratio(div_ratio),
    .presc_en(presc_en), .ref_sel(ref_sel), .cp_hi(cp_hi),
    .drive_off(drive_off), .test_en(test_en), .port_out(port_out),
    .cp_mode(cp_mode), .mon_route(mon_route));

  function automatic logic [2:0] exp_port(logic [26:0] w);
    return w[23] ? {w[26], 2'b00} : w[26:24];
  endfunction

  function automatic logic [1:0] exp_mode(logic [26:0] w);
    if (!w[23]) return 2'd0;
    case (w[25:24])
      2'b00: return 2'd1;
      2'b01: return 2'd2;
      2'b10: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk({req, " div_ratio"}, 32'(div_ratio), 32'(div_w[16:0]));
    chk({req, " presc_en"}, 32'(presc_en), 32'(div_w[17]));
    chk({req, " ref_sel"}, 32'(ref_sel), 32'(div_w[20:18]));
    chk({req, " cp_hi"}, 32'(cp_hi), 32'(imm_w[21]));
    chk({req, " drive_off"}, 32'(drive_off), 32'(imm_w[22]));
    chk({req, " test_en"}, 32'(test_en), 32'(imm_w[23]));
    chk({req, " port_out R8"}, 32'(port_out), 32'(exp_port(imm_w)));
    chk({req, " cp_mode R9"}, 32'(cp_mode), 32'(exp_mode(imm_w)));
    chk({req, " mon_route R9"}, 32'(mon_route),
        32'(imm_w[23] && imm_w[25:24] == 2'b11));
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  // send n bits of val, MSB first; tc_same raises div_tc in acceptance cycle
  task automatic send(logic [31:0] val, int n, bit tc_same);
    @(negedge clk) bus_en = 1;
    wait_n(HALF);
    for (int i = n - 1; i >= 0; i--) begin
      bus_data = val[i];
      wait_n(HALF);
      bus_clk = 1;
      wait_n(HALF);
      bus_clk = 0;
    end
    wait_n(HALF);
    bus_en = 0;
    if (tc_same) begin
      wait_n(2);
      div_tc = 1;
      @(negedge clk) div_tc = 0;
    end
    wait_n(6);
    if (n == 27) begin
      imm_w = val[26:0];
      if (tc_same) begin div_w = val[26:0]; pend_v = 0; end
      else begin pend_w = val[26:0]; pend_v = 1; end
    end
  endtask

  task automatic pulse_tc();
    @(negedge clk) div_tc = 1;
    @(negedge clk) div_tc = 0;
    if (pend_v) begin div_w = pend_w; pend_v = 0; end
    wait_n(1);
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd1234);
    imm_w = '0; div_w = '0; pend_w = '0; pend_v = 0;
    wait_n(3);
    check_all("R1 reset-held");
    rst_n = 1;
    wait_n(3);
    check_all("R1 reset");

    // R2 / R5: immediate fields now, divider fields after tc
    send(32'h5A5_1234 | (32'h1 << 26), 27, 0);
    check_all("R2 immediate");
    chk("R5 div held", 32'(div_ratio), 32'h0);
    pulse_tc();
    check_all("R5 after tc");
    pulse_tc();
    check_all("R5 idle tc");

    // R3: bus clock pulses with enable low
    for (int i = 0; i < 10; i++) begin
      bus_data = i[0];
      wait_n(HALF); bus_clk = 1; wait_n(HALF); bus_clk = 0;
    end
    wait_n(6);
    check_all("R3 idle clocks");
    pulse_tc();
    check_all("R3 no pending");

    // R4: short and long frames discarded
    send(32'h7FF_FFFF, 26, 0);
    check_all("R4 short frame");
    send(32'hFFFF_FFFF, 28, 0);
    check_all("R4 long frame");
    pulse_tc();
    check_all("R4 nothing pending");

    // R6: tc lands in acceptance cycle
    send({5'd0, 3'b010, 1'b1, 1'b0, 1'b1, 3'b101, 1'b1, 17'h1ABCD}, 27, 1);
    check_all("R6 same-cycle");
    send({5'd0, 27'h0F0_F0F0}, 27, 0);
    wait_n(1);
    check_all("R6 next frame pending");
    pulse_tc();
    check_all("R6 applied later");

    // R7: second frame over pending one
    send({5'd0, 27'h2AA_AAAA}, 27, 0);
    send({5'd0, 27'h455_5555}, 27, 0);
    check_all("R7 both pending");
    pulse_tc();
    check_all("R7 newest applied");

    // R9 all test-mode selections
    for (int m = 0; m < 4; m++) begin
      send({5'd0, 1'b1, m[1:0], 1'b1, 6'd0, 17'h00100}, 27, 0);
      check_all("R9 mode");
    end

    // random frames
    for (int it = 0; it < 30; it++) begin
      logic [26:0] w;
      w = 27'($urandom);
      send({5'd0, w}, 27, ($urandom % 4) == 0);
      check_all("R2 random");
      if ($urandom % 2) begin
        pulse_tc();
        check_all("R5 random tc");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule